// File: doc/BRIEF.md
# AES-128 Encryption Coprocessor

This block is an iterative AES-128 encryption engine that sits beside a 32-bit processor as a coprocessor. The host loads the 128-bit cipher key and the 128-bit plaintext one 32-bit word at a time into internal key and block holding registers. It then issues a start request with the crypt enable raised. The engine copies the loaded block and key into its own working state and round-key registers. It runs one cipher round per clock and raises a ready flag once the ciphertext can be read back word by word.

Round keys are derived on the fly from the previous round key, one per round, so no expanded key schedule is stored. The holding registers stay frozen while a run is in flight. The working state can only be changed by the round sequence, and the caller may prepare the next block as soon as ready is seen.

Top module: `aes128_cop`

## Requirements
- R1: After reset, ready is low and all four readback words are zero.
- R2: A write with wr_en high stores wr_data into the key register (wr_key=1) or the plaintext register (wr_key=0). wr_addr selects the word, and word 0 holds the most significant 32 bits, which are the first four bytes. Words may be written in any order, for example the upper pair (addresses 0,1) after the lower pair (addresses 2,3).
- R3: A start sampled with crypt_en high while idle begins a run. A start sampled with crypt_en low has no effect: ready stays as it was.
- R4: ready goes low on the clock edge that accepts a start. It goes high exactly 10 clock edges later and stays high until the next accepted start.
- R5: The result equals the AES-128 encryption of the loaded plaintext under the loaded key. This covers 10 rounds with round constants 01,02,04,08,10,20,40,80,1B,36, and no column mixing in the last round.
- R6: A start sampled while a run is in progress is ignored. The run finishes on its original schedule with the correct result.
- R7: Key or plaintext writes sampled while a run is in progress are dropped. Neither the running result nor a later run that uses the stored registers is affected.
- R8: rd_data presents the result word chosen by rd_addr, with word 0 holding the most significant 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crypt_en | input | 1 | Crypt enable; a start counts only while it is high |
| start | input | 1 | Start request |
| wr_en | input | 1 | Word write strobe |
| wr_key | input | 1 | 1 selects the key register, 0 the plaintext register |
| wr_addr | input | 2 | Word index of the write, 0 = most significant |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word index of the readback, 0 = most significant |
| rd_data | output | 32 | Selected result word |
| ready | output | 1 | Result valid, held until the next accepted start |

## Verification
The engine is run on three known key and plaintext pairs: the counting key with the counting plaintext, the all-zero key with the all-zero block, and a third pair with irregular bytes. Every S-box, row shift, column mix and key-schedule error then shows up in all four words. The all-zero pair separates the S-box constant and the round-constant chain from any data-dependent path. One run is disturbed with a stray start and with key and plaintext writes in the middle of the rounds. It is then repeated without reloading, which shows whether the running state or the stored registers were touched. Start requests with the enable low, and the hold of ready across idle cycles, are checked as well.

// File: rtl/aes128_cop_pkg.sv
package aes128_cop_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam int BLK_W  = WORD_W * NWORDS;
  localparam int NBYTES = BLK_W / 8;

  // multiply by x in GF(2^8)
  function automatic logic [7:0] gf_x2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_x2(p);
    end
    return acc;
  endfunction

  // inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h01;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) acc = gf_mul(acc, p);
      p = gf_mul(p, p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes128_keystep.sv
module aes128_keystep
  import aes128_cop_pkg::*;
(
  input  logic [BLK_W-1:0] cur_key,
  input  logic [7:0]       rcon,
  output logic [BLK_W-1:0] nxt_key
);
  logic [WORD_W-1:0] w_in  [NWORDS];
  logic [WORD_W-1:0] w_out [NWORDS];
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] mix_w;

  for (genvar i = 0; i < NWORDS; i++) begin : g_split
    assign w_in[i] = cur_key[BLK_W-1-WORD_W*i -: WORD_W];
    assign nxt_key[BLK_W-1-WORD_W*i -: WORD_W] = w_out[i];
  end

  assign rot_w = {w_in[NWORDS-1][WORD_W-9:0], w_in[NWORDS-1][WORD_W-1 -: 8]};

  for (genvar b = 0; b < WORD_W/8; b++) begin : g_sub
    if (b == 0) begin : g_rc
      assign mix_w[WORD_W-1 -: 8] = sub_byte(rot_w[WORD_W-1 -: 8]) ^ rcon;
    end else begin : g_plain
      assign mix_w[WORD_W-1-8*b -: 8] = sub_byte(rot_w[WORD_W-1-8*b -: 8]);
    end
  end

  assign w_out[0] = w_in[0] ^ mix_w;
  for (genvar i = 1; i < NWORDS; i++) begin : g_chain
    assign w_out[i] = w_in[i] ^ w_out[i-1];
  end
endmodule

// File: rtl/aes128_round.sv
module aes128_round
  import aes128_cop_pkg::*;
(
  input  logic [BLK_W-1:0] st_in,
  input  logic [BLK_W-1:0] rkey,
  input  logic             final_rnd,
  output logic [BLK_W-1:0] st_out
);
  logic [7:0] sb [NBYTES];
  logic [7:0] sr [NBYTES];
  logic [7:0] mc [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_bytes
    assign sb[i] = sub_byte(st_in[BLK_W-1-8*i -: 8]);
    // byte i sits at row i%4, column i/4; row r rotates left by r
    assign sr[i] = sb[(i % 4) + 4 * (((i / 4) + (i % 4)) % 4)];
    assign st_out[BLK_W-1-8*i -: 8] = (final_rnd ? sr[i] : mc[i]) ^ rkey[BLK_W-1-8*i -: 8];
  end

  for (genvar c = 0; c < 4; c++) begin : g_cols
    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr[4*c];
    assign a1 = sr[4*c+1];
    assign a2 = sr[4*c+2];
    assign a3 = sr[4*c+3];
    assign mc[4*c]   = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
    assign mc[4*c+1] = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
    assign mc[4*c+2] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
    assign mc[4*c+3] = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
  end
endmodule

// File: rtl/aes128_seq.sv
module aes128_seq #(
  parameter int ROUNDS = 10,
  localparam int CNT_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             go,
  output logic             busy,
  output logic             load,
  output logic             final_rnd,
  output logic [CNT_W-1:0] rnd,
  output logic             ready
);
  logic             busy_q, busy_d;
  logic             rdy_q, rdy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign load      = go && !busy_q;
  assign final_rnd = (cnt_q == CNT_W'(ROUNDS));

  always_comb begin
    busy_d = busy_q;
    rdy_d  = rdy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      rdy_d  = 1'b0;
      cnt_d  = CNT_W'(1);
    end else if (busy_q) begin
      if (final_rnd) begin
        busy_d = 1'b0;
        rdy_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rdy_q  <= rdy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy  = busy_q;
  assign rnd   = cnt_q;
  assign ready = rdy_q;
endmodule

// File: rtl/aes128_cop.sv
module aes128_cop
  import aes128_cop_pkg::*;
#(
  parameter int ROUNDS = 10,
  localparam int AW    = $clog2(NWORDS),
  localparam int CNT_W = $clog2(ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crypt_en,
  input  logic              start,
  input  logic              wr_en,
  input  logic              wr_key,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              ready
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             busy, load, final_rnd;
  logic [CNT_W-1:0] rnd;
  logic [BLK_W-1:0] key_q, buf_q, st_q, rk_q;
  logic [BLK_W-1:0] st_d, rk_d, rnd_out, nk;
  logic [7:0]       rc_q, rc_d;
  logic             key_we, buf_we, st_en;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  aes128_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk(clk), .rst_ni(rst_i), .go(start && crypt_en),
    .busy(busy), .load(load), .final_rnd(final_rnd), .rnd(rnd), .ready(ready)
  );

  aes128_keystep u_ks (.cur_key(rk_q), .rcon(rc_q), .nxt_key(nk));

  aes128_round u_rnd (.st_in(st_q), .rkey(nk), .final_rnd(final_rnd), .st_out(rnd_out));

  assign key_we = wr_en && wr_key && !busy;
  assign buf_we = wr_en && !wr_key && !busy;
  assign st_en  = load || busy;

  always_comb begin
    if (load) begin
      st_d = buf_q ^ key_q;
      rk_d = key_q;
      rc_d = 8'h01;
    end else begin
      st_d = rnd_out;
      rk_d = nk;
      rc_d = gf_x2(rc_q);
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_regs
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        key_q[BLK_W-1-WORD_W*w -: WORD_W] <= '0;
        buf_q[BLK_W-1-WORD_W*w -: WORD_W] <= '0;
      end else begin
        if (key_we && (wr_addr == AW'(w))) key_q[BLK_W-1-WORD_W*w -: WORD_W] <= wr_data;
        if (buf_we && (wr_addr == AW'(w))) buf_q[BLK_W-1-WORD_W*w -: WORD_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= '0;
      rk_q <= '0;
      rc_q <= 8'h00;
    end else if (st_en) begin
      st_q <= st_d;
      rk_q <= rk_d;
      rc_q <= rc_d;
    end
  end

  assign rd_data = st_q[BLK_W-1-WORD_W*rd_addr -: WORD_W];
endmodule

// File: rtl/aes128_cop_chk.sv
module aes128_cop_chk #(
  parameter int ROUNDS = 10,
  parameter int BLK_W  = 128,
  localparam int CNT_W = $clog2(ROUNDS + 1)
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             start,
  input logic             crypt_en,
  input logic             ready,
  input logic             busy,
  input logic [CNT_W-1:0] rnd,
  input logic [BLK_W-1:0] key_q,
  input logic [BLK_W-1:0] buf_q
);
  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && crypt_en && !busy) |=> !ready);
  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ready && !(start && crypt_en)) |=> ready);
  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ready) |-> ($past(rnd) == CNT_W'(ROUNDS) && !busy));
  // R6
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && rnd != CNT_W'(ROUNDS)) |=> (busy && rnd == $past(rnd) + CNT_W'(1)));
  // R3
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && !crypt_en && !busy) |=> (!busy && $stable(ready)));
  // R7
  key_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(key_q));
  // R7
  buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(buf_q));
endmodule

bind aes128_cop aes128_cop_chk #(.ROUNDS(ROUNDS), .BLK_W(aes128_cop_pkg::BLK_W)) u_chk (
  .clk(clk), .rst_ni(rst_i), .start(start), .crypt_en(crypt_en), .ready(ready),
  .busy(busy), .rnd(rnd), .key_q(key_q), .buf_q(buf_q)
);

// File: tb/tb_aes128_cop.sv
module tb_aes128_cop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crypt_en = 1'b0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_key = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        ready;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] exp_q[$];
  bit done_all = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes128_cop dut (
    .clk(clk), .rst_n(rst_n), .crypt_en(crypt_en), .start(start),
    .wr_en(wr_en), .wr_key(wr_key), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
  );

  function automatic logic [31:0] wd(input logic [127:0] b, input int i);
    return b[127-32*i -: 32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_word(input bit k, input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_key = k; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2: key upper half after lower half, plaintext in ascending order
  task automatic load(input logic [127:0] key, input logic [127:0] pt);
    wr_word(1'b1, 2, wd(key, 2));
    wr_word(1'b1, 3, wd(key, 3));
    wr_word(1'b1, 0, wd(key, 0));
    wr_word(1'b1, 1, wd(key, 1));
    for (int i = 0; i < 4; i++) wr_word(1'b0, i, wd(pt, i));
  endtask

  // driver: push expected result, start, watch timing; optionally disturb the run
  task automatic run(input logic [127:0] ct, input bit disturb);
    int lat;
    exp_q.push_back(ct);
    crypt_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R4 ready low after start", 128'(ready), 128'd0);
    lat = 0;
    while (!ready && lat < 40) begin
      if (disturb && lat == 3) begin
        start = 1'b1;                                 // R6 stray start
        wr_en = 1'b1; wr_key = 1'b1; wr_addr = 2'd0; wr_data = 32'hdeadbeef; // R7
      end else if (disturb && lat == 5) begin
        start = 1'b0;
        wr_en = 1'b1; wr_key = 1'b0; wr_addr = 2'd2; wr_data = 32'h0badf00d; // R7
      end else begin
        start = 1'b0;
        wr_en = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    wr_en = 1'b0;
    check(lat == 10, disturb ? "R6 latency with stray start" : "R4 ready latency",
          128'(lat), 128'd10);
    repeat (6) @(negedge clk);
  endtask

  // monitor: on each rising ready, pop expected block and compare words (R5, R8)
  initial begin
    logic prev;
    logic [127:0] e;
    wait (rst_n);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_addr = 2'(i);
      #1;
      check(rd_data == 32'd0, "R1 readback zero after reset", 128'(rd_data), 128'd0);
    end
    prev = ready;
    forever begin
      @(negedge clk);
      if (ready && !prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", 128'd0, 128'd0);
        end else begin
          e = exp_q.pop_front();
          for (int i = 0; i < 4; i++) begin
            rd_addr = 2'(i);
            #1;
            check(rd_data == wd(e, i), "R5 R8 result word", 128'(rd_data), 128'(wd(e, i)));
          end
        end
      end
      prev = ready;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_all) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] k1, p1, c1, k2, p2, c2, c3;
    k1 = 128'h000102030405060708090a0b0c0d0e0f;
    p1 = 128'h00112233445566778899aabbccddeeff;
    c1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    k2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p2 = 128'h3243f6a8885a308d313198a2e0370734;
    c2 = 128'h3925841d02dc09fbdc118597196a0b32;
    c3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R1 ready low after reset", 128'(ready), 128'd0);
    repeat (6) @(negedge clk);

    load(k1, p1);
    run(c1, 1'b0);
    // R4 ready holds while idle
    check(ready == 1'b1, "R4 ready held", 128'(ready), 128'd1);
    // R3 start without crypt_en ignored
    crypt_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    check(ready == 1'b1, "R3 start without enable ignored", 128'(ready), 128'd1);

    load(128'd0, 128'd0);
    run(c3, 1'b0);

    load(k2, p2);
    run(c2, 1'b1);            // R6 R7 disturbed run still yields c2
    run(c2, 1'b0);            // R7 stored key and plaintext untouched

    load(k1, p1);
    run(c1, 1'b0);

    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    done_all = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule